// File: doc/BRIEF.md
# SPI Controller Command/Data Sequencer

This block is the transmit and receive engine of an SPI controller that sends 8-bit frames. It takes words from a transmit FIFO through a valid/pop pair, generates the serial clock from a programmable divider, shifts each word out most-significant bit first on the data output, and shifts the data input into a receive word. Each received word is handed on through a one-cycle push strobe.

The chip-select line does not select a device here. It tells the receiver whether a byte is a command or data: low means command, high means data. A 4-bit mode value sets how the line behaves over a transfer. It can hold the line high for a whole transfer, hold it low for a whole transfer, or hold it low for a counted number of leading bytes and then high for the rest. A repeat count sends each word from the FIFO several times without further writes. An optional parity bit takes the place of the last bit of each frame. The receive side checks that bit and reports a mismatch as an event.

The block also reports when it is busy. A one-cycle idle event fires when a transfer has fully drained. The surrounding logic uses that event, or the command countdown readback, to decide when to reconfigure the block or queue the next transfer.

Top module: `spi_cd_sequencer`

## Requirements
- R1: After reset, `spi_cs` is 1, `spi_sclk` equals `cfg_cpol`, and `busy`, `fifo_pop`, `rx_push`, `parity_err`, `idle_evt` are 0 and `cd_remaining` is 0.
- R2: Each frame has 8 bits, most-significant first. `spi_sclk` toggles 16 times per frame, once every `cfg_scr`+1 clock cycles (bit rate clk/((SCR+1)*2)), and it rests at `cfg_cpol` between frames.
- R3: With `cfg_cpha`=0, `spi_miso` is captured on the 1st, 3rd and later odd-numbered clock edges of a frame and `spi_mosi` changes on the edges in between. With `cfg_cpha`=1, capture moves to the 2nd, 4th and later even-numbered edges. The captured byte appears on `rx_data` with a one-cycle `rx_push`, in the clock cycle that follows the last SCLK edge.
- R4: `cfg_cd_mode`=0 holds `spi_cs` high for every frame of a transfer, and `cfg_cd_mode`=15 holds it low for every frame.
- R5: `cfg_cd_mode`=K with 1≤K≤14 drives `spi_cs` low for the first K frames of a transfer and high for the later frames. `cd_remaining` reads back the number of low frames still to come, which is max(K−frames sent, 0). In modes 0 and 15 it reads back the mode value.
- R6: The command countdown reloads from `cfg_cd_mode` whenever a frame starts while `busy` was low in the previous cycle.
- R7: With `cfg_repeat`=N, each FIFO word is sent N+1 times in a row before the next word is popped. `fifo_pop` pulses exactly once per word and only while `fifo_valid` is 1.
- R8: With `cfg_par_en`=1, the transmitted bit 0 is replaced by a parity bit over bits 7..1. The bit is the XOR of those bits when `cfg_par_even`=1 and the inverted XOR when it is 0.
- R9: With `cfg_par_en`=1, `parity_err` pulses together with `rx_push` when received bit 0 differs from the parity of received bits 7..1 under the same rule. With `cfg_par_en`=0 it never pulses.
- R10: `busy` is 1 while a frame is shifting, while `fifo_valid` is 1, or while repeats are pending. `idle_evt` is 1 for exactly one cycle, the first cycle in which `busy` is 0 after being 1.
- R11: While `cfg_en` is 0, no frame starts and nothing is popped. A word already waiting goes out once `cfg_en` returns to 1.
- R12: `spi_cs` changes only when a frame starts and keeps its value between frames and after a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Allows frames to start |
| cfg_cpol | input | 1 | SCLK resting level |
| cfg_cpha | input | 1 | 0: capture on first edge, 1: capture on second edge |
| cfg_scr | input | 10 | Half-period of SCLK minus one, in clock cycles |
| cfg_cd_mode | input | 4 | Command/data mode: 0 data, 15 command, 1..14 command byte count |
| cfg_repeat | input | 8 | Extra sends of each FIFO word |
| cfg_par_en | input | 1 | Parity in bit 0 of each frame |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| fifo_valid | input | 1 | Transmit FIFO holds a word |
| fifo_data | input | 8 | Word at the FIFO head |
| fifo_pop | output | 1 | Head word taken at this clock edge |
| rx_push | output | 1 | Received word valid (one cycle) |
| rx_data | output | 8 | Received word |
| spi_cs | output | 1 | Command (0) / data (1) indicator |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| cd_remaining | output | 4 | Command frames still to go |
| busy | output | 1 | Transfer in progress |
| idle_evt | output | 1 | Busy has just fallen |
| parity_err | output | 1 | Parity mismatch on the word now pushed |

## Verification
A frame starts at the clock edge where `fifo_pop` (or a repeat) is seen, and `spi_cs` and `cd_remaining` take their new values at that same edge. The SCLK toggles follow at intervals of `cfg_scr`+1 cycles. `rx_data`, `rx_push` and `parity_err` are registered and arrive one cycle after the sixteenth toggle. `idle_evt` appears in the first cycle `busy` reads low. The bench samples every output on the falling clock edge. It compares received words, chip-select level and parity result when `rx_push` itself is seen, not after a fixed delay. It measures SCLK intervals by counting falling edges between changes of level. End-of-transfer values are checked only after `busy` has settled low.

// File: rtl/spi_cd_pkg.sv
package spi_cd_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } seq_state_e;

  // Capture happens on the edge whose parity matches the phase setting.
  function automatic logic is_capture_edge(input logic cpha, input logic edge_lsb);
    return edge_lsb == cpha;
  endfunction

  // Launch happens on the other edges, except where there is no next bit
  // (phase 0: final edge) or the first bit is already on the line (phase 1: edge 0).
  function automatic logic is_launch_edge(input logic cpha, input logic edge_lsb,
                                          input logic first_edge, input logic final_edge);
    return (edge_lsb != cpha) && !(cpha ? first_edge : final_edge);
  endfunction

endpackage

// File: rtl/spi_cd_clkgen.sv
module spi_cd_clkgen #(
  parameter int SCR_W = 10,
  parameter int EW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             cpol,
  input  logic [SCR_W-1:0] scr,
  output logic             sclk,
  output logic             tick,
  output logic [EW-1:0]    edge_idx,
  output logic             last_edge
);
  localparam logic [EW-1:0] FINAL_EDGE = {EW{1'b1}};

  logic [SCR_W-1:0] half_cnt;

  assign tick      = run && (half_cnt == scr);
  assign last_edge = tick && (edge_idx == FINAL_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      edge_idx <= '0;
      sclk     <= 1'b0;
    end else if (start) begin
      half_cnt <= '0;
      edge_idx <= '0;
      sclk     <= cpol;
    end else if (run) begin
      if (tick) begin
        half_cnt <= '0;
        edge_idx <= edge_idx + 1'b1;
        sclk     <= ~sclk;
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end else begin
      sclk <= cpol;
    end
  end

  assert_sclk_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> (sclk == $past(cpol)));

  assert_tick_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sclk != $past(sclk)));

endmodule

// File: rtl/spi_cd_shifter.sv
module spi_cd_shifter
  import spi_cd_pkg::*;
#(
  parameter int DW = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          cpha,
  input  logic          tick,
  input  logic          last_edge,
  input  logic [EW-1:0] edge_idx,
  input  logic          miso,
  output logic          mosi,
  output logic          rx_push,
  output logic [DW-1:0] rx_data,
  output logic          par_err
);
  localparam logic [EW-1:0] FINAL_EDGE = {EW{1'b1}};

  function automatic logic parity_over_upper(input logic [DW-1:0] w, input logic even);
    return even ? (^w[DW-1:1]) : ~(^w[DW-1:1]);
  endfunction

  logic [DW-1:0] tx_sr, rx_sr, rx_next, rx_final, tx_word;
  logic          capture_now, launch_now;

  assign capture_now = tick && is_capture_edge(cpha, edge_idx[0]);
  assign launch_now  = tick && is_launch_edge(cpha, edge_idx[0], edge_idx == '0,
                                              edge_idx == FINAL_EDGE);
  assign rx_next     = {rx_sr[DW-2:0], miso};
  assign rx_final    = capture_now ? rx_next : rx_sr;
  assign tx_word     = par_en ? {load_data[DW-1:1], parity_over_upper(load_data, par_even)}
                              : load_data;
  assign mosi        = tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_data <= '0;
      rx_push <= 1'b0;
      par_err <= 1'b0;
    end else begin
      rx_push <= last_edge;
      par_err <= last_edge && par_en &&
                 (rx_final[0] != parity_over_upper(rx_final, par_even));
      if (last_edge) rx_data <= rx_final;
      if (capture_now) rx_sr <= rx_next;
      if (load) tx_sr <= tx_word;
      else if (launch_now) tx_sr <= {tx_sr[DW-2:0], 1'b0};
    end
  end

  assert_push_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  assert_perr_on_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rx_push);

endmodule

// File: rtl/spi_cd_ctrl.sv
module spi_cd_ctrl
  import spi_cd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CD_W  = 4,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [CD_W-1:0]  cfg_cd_mode,
  input  logic [REP_W-1:0] cfg_repeat,
  input  logic             fifo_valid,
  input  logic [DW-1:0]    fifo_data,
  output logic             fifo_pop,
  input  logic             frame_done,
  output logic             start,
  output logic             run,
  output logic [DW-1:0]    load_data,
  output logic             spi_cs,
  output logic             busy,
  output logic             idle_evt,
  output logic [CD_W-1:0]  cd_remaining
);
  localparam logic [CD_W-1:0] MODE_DATA = '0;
  localparam logic [CD_W-1:0] MODE_CMD  = {CD_W{1'b1}};

  function automatic logic cs_for(input logic [CD_W-1:0] mode, input logic [CD_W-1:0] left);
    if (mode == MODE_DATA) return 1'b1;
    if (mode == MODE_CMD)  return 1'b0;
    return left == '0;
  endfunction

  function automatic logic [CD_W-1:0] count_after(input logic [CD_W-1:0] mode,
                                                  input logic [CD_W-1:0] left);
    if (mode == MODE_DATA || mode == MODE_CMD || left == '0) return left;
    return left - 1'b1;
  endfunction

  seq_state_e       state;
  logic [REP_W-1:0] rep_cnt;
  logic [DW-1:0]    hold_word;
  logic [CD_W-1:0]  cd_cnt, cd_base;
  logic             busy_q, repeating, fresh;

  assign repeating    = rep_cnt != '0;
  assign run          = state == ST_SHIFT;
  assign start        = !run && cfg_en && (repeating || fifo_valid);
  assign fifo_pop     = start && !repeating;
  assign load_data    = repeating ? hold_word : fifo_data;
  assign busy         = run || fifo_valid || repeating;
  assign idle_evt     = busy_q && !busy;
  assign fresh        = !busy_q;
  assign cd_base      = fresh ? cfg_cd_mode : cd_cnt;
  assign cd_remaining = cd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rep_cnt   <= '0;
      hold_word <= '0;
      cd_cnt    <= '0;
      spi_cs    <= 1'b1;
      busy_q    <= 1'b0;
    end else begin
      busy_q <= busy;
      if (start) begin
        state  <= ST_SHIFT;
        spi_cs <= cs_for(cfg_cd_mode, cd_base);
        cd_cnt <= count_after(cfg_cd_mode, cd_base);
        if (repeating) begin
          rep_cnt <= rep_cnt - 1'b1;
        end else begin
          rep_cnt   <= cfg_repeat;
          hold_word <= fifo_data;
        end
      end else if (frame_done) begin
        state <= ST_IDLE;
      end
    end
  end

  assert_pop_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_valid && !repeating));

  assert_cs_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(spi_cs));

  assert_idle_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> !idle_evt);

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> (cd_remaining <= $past(cd_remaining)));

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !run) |=> !run);

endmodule

// File: rtl/spi_cd_sequencer.sv
module spi_cd_sequencer #(
  parameter int DW    = 8,
  parameter int SCR_W = 10,
  parameter int CD_W  = 4,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [SCR_W-1:0] cfg_scr,
  input  logic [CD_W-1:0]  cfg_cd_mode,
  input  logic [REP_W-1:0] cfg_repeat,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic             fifo_valid,
  input  logic [DW-1:0]    fifo_data,
  output logic             fifo_pop,
  output logic             rx_push,
  output logic [DW-1:0]    rx_data,
  output logic             spi_cs,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [CD_W-1:0]  cd_remaining,
  output logic             busy,
  output logic             idle_evt,
  output logic             parity_err
);
  localparam int EW = $clog2(2 * DW);

  logic          frame_start, frame_run, sclk_tick, frame_last;
  logic [EW-1:0] edge_idx;
  logic [DW-1:0] load_word;

  spi_cd_ctrl #(.DW(DW), .CD_W(CD_W), .REP_W(REP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cd_mode(cfg_cd_mode),
    .cfg_repeat(cfg_repeat), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .frame_done(frame_last), .start(frame_start), .run(frame_run),
    .load_data(load_word), .spi_cs(spi_cs), .busy(busy), .idle_evt(idle_evt),
    .cd_remaining(cd_remaining)
  );

  spi_cd_clkgen #(.SCR_W(SCR_W), .EW(EW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .run(frame_run), .cpol(cfg_cpol),
    .scr(cfg_scr), .sclk(spi_sclk), .tick(sclk_tick), .edge_idx(edge_idx),
    .last_edge(frame_last)
  );

  spi_cd_shifter #(.DW(DW), .EW(EW)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_data(load_word),
    .par_en(cfg_par_en), .par_even(cfg_par_even), .cpha(cfg_cpha), .tick(sclk_tick),
    .last_edge(frame_last), .edge_idx(edge_idx), .miso(spi_miso), .mosi(spi_mosi),
    .rx_push(rx_push), .rx_data(rx_data), .par_err(parity_err)
  );

endmodule

// File: tb/spi_cd_sequencer_tb.sv
module spi_cd_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_en = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [9:0] cfg_scr = 10'd0;
  logic [3:0] cfg_cd_mode = 4'd0;
  logic [7:0] cfg_repeat = 8'd0;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0;
  logic       fifo_valid, fifo_pop, rx_push, spi_cs, spi_sclk, spi_mosi, spi_miso;
  logic       busy, idle_evt, parity_err, miso_stuck = 1'b0;
  logic [7:0] fifo_data, rx_data;
  logic [3:0] cd_remaining;

  logic [7:0] fifo_mem [16];
  int fifo_cnt = 0, fifo_rd = 0;
  bit pop_flag = 0;
  assign fifo_valid = fifo_rd < fifo_cnt;
  assign fifo_data  = fifo_mem[fifo_rd[3:0]];
  assign spi_miso   = miso_stuck ? 1'b1 : spi_mosi;

  spi_cd_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_scr(cfg_scr), .cfg_cd_mode(cfg_cd_mode), .cfg_repeat(cfg_repeat),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .rx_push(rx_push), .rx_data(rx_data),
    .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .cd_remaining(cd_remaining), .busy(busy), .idle_evt(idle_evt), .parity_err(parity_err)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_byte [64];
  logic       exp_cs [64];
  logic       exp_perr [64];
  int n_exp = 0;

  bit mon_on = 0;
  int cyc = 0, last_tog = 0, tog = 0, ival_bad = 0, pops = 0, frames = 0, idles = 0;
  logic sclk_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit odd_ones(input logic [7:0] w);
    int c = 0;
    for (int i = 1; i < 8; i++) c += int'(w[i]);
    return (c % 2) == 1;
  endfunction

  function automatic logic par_bit(input logic [7:0] w, input bit even);
    return even ? odd_ones(w) : !odd_ones(w);
  endfunction

  function automatic logic cs_model(input int mode, input int j);
    if (mode == 0) return 1'b1;
    if (mode == 15) return 1'b0;
    return (j < mode) ? 1'b0 : 1'b1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (pop_flag) fifo_rd++;
    pop_flag = fifo_pop;
    if (mon_on && fifo_pop) pops++;
    if (spi_sclk !== sclk_prev) begin
      if (mon_on) begin
        if ((tog % 16) != 0 && (cyc - last_tog) != int'(cfg_scr) + 1) ival_bad++;
        tog++;
      end
      last_tog = cyc;
      sclk_prev = spi_sclk;
    end
    if (mon_on && idle_evt) idles++;
    if (mon_on && rx_push) begin
      if (frames < n_exp) begin
        chk(rx_data == exp_byte[frames], "R3 R8 received word", rx_data, exp_byte[frames]);
        chk(spi_cs == exp_cs[frames], "R4 R5 R6 cs level", spi_cs, exp_cs[frames]);
        chk(parity_err == exp_perr[frames], "R9 parity flag", parity_err, exp_perr[frames]);
      end
      frames++;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_xfer(input bit cpol, input bit cpha, input int scr, input int mode,
                          input int rep, input bit pe, input bit ev, input bit stuck,
                          input int nw);
    int j = 0;
    int t = 0;
    int rem;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_scr = 10'(scr); cfg_cd_mode = 4'(mode);
    cfg_repeat = 8'(rep); cfg_par_en = pe; cfg_par_even = ev; miso_stuck = stuck;
    for (int w = 0; w < nw; w++) begin
      logic [7:0] word = 8'($urandom);
      logic [7:0] tx = pe ? {word[7:1], par_bit(word, ev)} : word;
      logic [7:0] rx = stuck ? 8'hFF : tx;
      fifo_mem[w] = word;
      for (int r = 0; r <= rep; r++) begin
        exp_byte[j] = rx;
        exp_cs[j]   = cs_model(mode, j);
        exp_perr[j] = pe && (rx[0] != par_bit(rx, ev));
        j++;
      end
    end
    n_exp = j;
    wait_cycles(3);
    tog = 0; ival_bad = 0; pops = 0; frames = 0; idles = 0;
    mon_on = 1;
    fifo_cnt = 0; fifo_rd = 0; fifo_cnt = nw;
    while (!(frames >= n_exp && !busy) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 5000, "R10 transfer drained", t, 5000);
    wait_cycles(3);
    mon_on = 0;
    chk(frames == n_exp, "R7 frames sent", frames, n_exp);
    chk(pops == nw, "R7 words popped", pops, nw);
    chk(tog == 16 * n_exp, "R2 sclk toggles", tog, 16 * n_exp);
    chk(ival_bad == 0, "R2 sclk half period", ival_bad, 0);
    chk(spi_sclk == cpol, "R2 sclk rest level", spi_sclk, cpol);
    chk(idles == 1, "R10 idle events", idles, 1);
    chk(busy == 1'b0, "R10 busy low", busy, 0);
    if (mode == 0 || mode == 15) rem = mode;
    else rem = (n_exp >= mode) ? 0 : mode - n_exp;
    chk(cd_remaining == 4'(rem), "R5 countdown readback", cd_remaining, rem);
    chk(spi_cs == exp_cs[n_exp-1], "R12 cs held", spi_cs, exp_cs[n_exp-1]);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin
    #(190000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);
    // R1 reset state
    chk(spi_cs == 1'b1, "R1 cs after reset", spi_cs, 1);
    chk(spi_sclk == 1'b0, "R1 sclk after reset", spi_sclk, 0);
    chk(busy == 1'b0 && fifo_pop == 1'b0, "R1 busy/pop after reset", busy, 0);
    chk(rx_push == 1'b0 && parity_err == 1'b0 && idle_evt == 1'b0,
        "R1 events after reset", rx_push, 0);
    chk(cd_remaining == 4'd0, "R1 countdown after reset", cd_remaining, 0);

    // Directed: manual data, manual command, counted command bytes
    run_xfer(0, 0, 0, 0, 0, 0, 0, 0, 3);
    run_xfer(1, 1, 2, 15, 0, 0, 0, 0, 3);
    run_xfer(0, 1, 5, 3, 0, 0, 0, 0, 5);
    // R6: counted mode twice in a row, second transfer reloads
    run_xfer(0, 0, 1, 3, 0, 0, 0, 0, 2);
    run_xfer(1, 0, 1, 3, 0, 0, 0, 0, 2);
    // R7 repeats interleaved with command countdown
    run_xfer(0, 0, 0, 4, 2, 0, 0, 0, 2);
    // R8 R9 parity: clean, stuck line odd (error), stuck even (clean), disabled
    run_xfer(0, 0, 1, 0, 0, 1, 1, 0, 3);
    run_xfer(1, 1, 0, 0, 0, 1, 0, 1, 2);
    run_xfer(0, 1, 0, 0, 0, 1, 1, 1, 2);
    run_xfer(0, 0, 0, 0, 0, 0, 0, 1, 2);

    // R11: disabled engine holds a waiting word
    cfg_en = 1'b0; cfg_cd_mode = 4'd0; cfg_repeat = 8'd0; cfg_par_en = 1'b0;
    miso_stuck = 1'b0; cfg_scr = 10'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    fifo_mem[0] = 8'hA5;
    n_exp = 1; exp_byte[0] = 8'hA5; exp_cs[0] = 1'b1; exp_perr[0] = 1'b0;
    wait_cycles(3);
    tog = 0; pops = 0; frames = 0; idles = 0; mon_on = 1;
    fifo_cnt = 0; fifo_rd = 0; fifo_cnt = 1;
    wait_cycles(40);
    chk(pops == 0 && frames == 0, "R11 no pop while disabled", pops, 0);
    chk(tog == 0, "R11 sclk quiet while disabled", tog, 0);
    cfg_en = 1'b1;
    wait_cycles(60);
    mon_on = 0;
    chk(frames == 1, "R11 sent after enable", frames, 1);

    // Random configurations
    for (int k = 0; k < 10; k++) begin
      run_xfer(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 4),
               int'($urandom % 16), int'($urandom % 3), bit'($urandom % 2),
               bit'($urandom % 2), ($urandom % 4) == 0, 1 + int'($urandom % 4));
    end

    summary();
    $finish;
  end
endmodule